// File: doc/BRIEF.md
# Multi-Channel Byte-Copy DMA Sequencer

The block is an eight-channel DMA engine that copies single bytes between a wide A-side address (an 8-bit bank above a 16-bit offset) and a narrow peripheral register window on the B side. Software, or a host model, loads each channel's registers over a one-shot configuration port. It then writes a channel mask to the arm port. After a one-cycle start delay the engine serves the armed channels one at a time, lowest index first. Each channel runs to completion, and the engine issues one bus request per byte.

The B-side address is a fixed window base combined with the channel's destination byte plus a small offset. The offset follows a four-entry pattern that the channel's 3-bit mode selects. The A-side offset can count up, count down or stay put. A per-channel flag chooses whether a byte moves from B to A or from A to B. A separate, higher-priority scanline engine can clear channels through a kill port. A cleared channel stops at once, and service moves to the next active channel.

Top module: `gdma_engine`

## Requirements
- R1: A pulse on `arm_we` sets the active flag of every channel whose bit in `arm_mask` is 1 and leaves all other active flags unchanged. The flags are visible on `chan_active`, bit n for channel n.
- R2: When the engine is idle, the first `bus_req` after an arm write appears no earlier than the second rising edge after the edge that captured the write.
- R3: Only the lowest-numbered active channel is served. A channel's bytes all go out before any byte of a higher-numbered channel.
- R4: `bus_a_addr` is {bank, offset}. When `cfg_fixed` is set the offset holds. Otherwise, when `cfg_decr` is set it decrements by one after each byte, and when neither flag is set it increments by one. The offset wraps modulo 2^16 and the bank never changes.
- R5: `bus_b_addr` is 0x2100 OR (dest + k) mod 256. The value k comes from the mode and from bits [1:0] of a byte index that starts at 0 for each channel run. By index 0..3 it is: modes 0, 2 and 6 give 0,0,0,0; mode 1 gives 0,1,0,0; modes 3 and 7 give 0,0,1,1; mode 4 gives 0,1,2,3; mode 5 gives 0,1,0,1.
- R6: `bus_b_to_a` equals the served channel's direction flag. A value of 1 means the byte moves from B to A.
- R7: The channel's size register drops by one after each acknowledged byte. The channel stops, and its active flag clears, when the size becomes zero. A loaded size of 0 therefore moves 2^SIZE_W bytes.
- R8: A `kill_we` pulse clears the active flags selected by `kill_mask`. The pulse overrides an arm bit in the same cycle. A killed channel moves no further byte. The next channel served starts at byte index 0.
- R9: While `bus_req` is high and `bus_ack` is low, the request and its addresses and direction hold unchanged.
- R10: `busy` is high exactly when some channel is active, and `bus_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load all registers of channel `cfg_ch` |
| cfg_ch | input | CH_W | Channel being configured |
| cfg_bank | input | BANK_W | A-side bank byte |
| cfg_addr | input | ADDR_W | A-side 16-bit start offset |
| cfg_size | input | SIZE_W | Byte count (0 means 2^SIZE_W) |
| cfg_dest | input | DEST_W | B-side destination byte |
| cfg_mode | input | 3 | B-offset pattern select |
| cfg_b_to_a | input | 1 | Direction, 1 = B to A |
| cfg_decr | input | 1 | Count the A offset down |
| cfg_fixed | input | 1 | Hold the A offset (wins over cfg_decr) |
| arm_we | input | 1 | Arm write strobe |
| arm_mask | input | NUM_CH | Channels to set active |
| kill_we | input | 1 | Scanline-engine clear strobe |
| kill_mask | input | NUM_CH | Channels to clear |
| bus_req | output | 1 | Byte request |
| bus_a_addr | output | BANK_W+ADDR_W | A-side address |
| bus_b_addr | output | B_W | B-side address |
| bus_b_to_a | output | 1 | Direction of this byte |
| bus_ack | input | 1 | Byte accepted |
| busy | output | 1 | Some channel active |
| chan_active | output | NUM_CH | Per-channel active flags |

## Verification
The bench sweeps every mode, every A-step choice and both directions with a destination near 0xFF and an offset near 0xFFFF. A wrong entry in the offset table, a missing 8-bit wrap, or an A-step that reaches into the bank would each give a wrong address on some byte. A zero size must produce 256 bytes in the bench configuration. An engine that tests the count before moving the byte would send none. Arm writes are sent while the engine is waiting. An engine that overwrote the flags instead of setting them would lose channels. It would also send its first request in the wrong cycle if it skipped the start delay. A channel is killed in mid-run. An engine that let it finish, or carried its byte index into the next channel, would send extra bytes or shifted B addresses. Withheld acknowledges check that the request holds steady.

// File: rtl/gdma_pkg.sv
package gdma_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_state_t;

   // B-side offset for a transfer mode and the low two bits of the byte index
   function automatic logic [1:0] b_step_offset(input logic [2:0] mode, input logic [1:0] idx);
      logic [1:0] r;
      case (mode)
         3'd1:        r = (idx == 2'd1) ? 2'd1 : 2'd0;
         3'd3, 3'd7:  r = {1'b0, idx[1]};
         3'd4:        r = idx;
         3'd5:        r = {1'b0, idx[0]};
         default:     r = 2'd0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/gdma_pick.sv
module gdma_pick #(
   parameter int NUM_CH    = 8,
   parameter int CH_W      = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [NUM_CH-1:0] req_mask,
   output logic              any,
   output logic [CH_W-1:0]   pick
);

   if (NUM_CH < 2 || (1 << CH_W) < NUM_CH) begin : g_bad_cfg
      $error("gdma_pick: CH_W too small for NUM_CH");
   end

   assign any = |req_mask;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         pick = '0;
         for (int i = NUM_CH - 1; i >= 0; i--)
            if (req_mask[i]) pick = CH_W'(i);
      end
   end else begin : g_high
      always_comb begin
         pick = '0;
         for (int i = 0; i < NUM_CH; i++)
            if (req_mask[i]) pick = CH_W'(i);
      end
   end

endmodule

// File: rtl/gdma_chan_regs.sv
module gdma_chan_regs #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3,
   parameter int SIZE_W = 16,
   parameter int ADDR_W = 16,
   parameter int BANK_W = 8,
   parameter int DEST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [BANK_W-1:0] cfg_bank,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic [DEST_W-1:0] cfg_dest,
   input  logic [2:0]        cfg_mode,
   input  logic              cfg_b_to_a,
   input  logic              cfg_decr,
   input  logic              cfg_fixed,
   input  logic              arm_we,
   input  logic [NUM_CH-1:0] arm_mask,
   input  logic              kill_we,
   input  logic [NUM_CH-1:0] kill_mask,
   input  logic              step_en,
   input  logic [CH_W-1:0]   step_ch,
   input  logic              step_last,
   input  logic [ADDR_W-1:0] step_addr,
   input  logic [SIZE_W-1:0] step_size,
   input  logic [CH_W-1:0]   sel_ch,
   output logic [NUM_CH-1:0] active,
   output logic [BANK_W-1:0] sel_bank,
   output logic [ADDR_W-1:0] sel_addr,
   output logic [SIZE_W-1:0] sel_size,
   output logic [DEST_W-1:0] sel_dest,
   output logic [2:0]        sel_mode,
   output logic              sel_b_to_a,
   output logic              sel_decr,
   output logic              sel_fixed
);

   logic [BANK_W-1:0] bank_q [NUM_CH];
   logic [ADDR_W-1:0] addr_q [NUM_CH];
   logic [SIZE_W-1:0] size_q [NUM_CH];
   logic [DEST_W-1:0] dest_q [NUM_CH];
   logic [2:0]        mode_q [NUM_CH];
   logic [NUM_CH-1:0] dir_q, decr_q, fixed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= '0;
         dir_q   <= '0;
         decr_q  <= '0;
         fixed_q <= '0;
         for (int i = 0; i < NUM_CH; i++) begin
            bank_q[i] <= '0;
            addr_q[i] <= '0;
            size_q[i] <= '0;
            dest_q[i] <= '0;
            mode_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (cfg_we && cfg_ch == CH_W'(i)) begin
               bank_q[i]  <= cfg_bank;
               addr_q[i]  <= cfg_addr;
               size_q[i]  <= cfg_size;
               dest_q[i]  <= cfg_dest;
               mode_q[i]  <= cfg_mode;
               dir_q[i]   <= cfg_b_to_a;
               decr_q[i]  <= cfg_decr;
               fixed_q[i] <= cfg_fixed;
            end else if (step_en && step_ch == CH_W'(i)) begin
               addr_q[i] <= step_addr;
               size_q[i] <= step_size;
            end
            // set, then completion, then kill: later lines take precedence
            if (arm_we && arm_mask[i])                      active[i] <= 1'b1;
            if (step_en && step_last && step_ch == CH_W'(i)) active[i] <= 1'b0;
            if (kill_we && kill_mask[i])                    active[i] <= 1'b0;
         end
      end
   end

   assign sel_bank   = bank_q[sel_ch];
   assign sel_addr   = addr_q[sel_ch];
   assign sel_size   = size_q[sel_ch];
   assign sel_dest   = dest_q[sel_ch];
   assign sel_mode   = mode_q[sel_ch];
   assign sel_b_to_a = dir_q[sel_ch];
   assign sel_decr   = decr_q[sel_ch];
   assign sel_fixed  = fixed_q[sel_ch];

endmodule

// File: rtl/gdma_addr_gen.sv
module gdma_addr_gen
   import gdma_pkg::*;
#(
   parameter int             SIZE_W = 16,
   parameter int             ADDR_W = 16,
   parameter int             BANK_W = 8,
   parameter int             DEST_W = 8,
   parameter int             B_W    = 16,
   parameter logic [B_W-1:0] B_BASE = 'h2100
) (
   input  logic [BANK_W-1:0]        bank,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [SIZE_W-1:0]        size,
   input  logic [DEST_W-1:0]        dest,
   input  logic [2:0]               mode,
   input  logic                     decr,
   input  logic                     fixed,
   input  logic [1:0]               idx,
   output logic [BANK_W+ADDR_W-1:0] a_addr,
   output logic [B_W-1:0]           b_addr,
   output logic [ADDR_W-1:0]        addr_next,
   output logic [SIZE_W-1:0]        size_next,
   output logic                     last
);

   if (B_W < DEST_W || DEST_W < 2) begin : g_bad_cfg
      $error("gdma_addr_gen: B window narrower than destination byte");
   end

   logic [DEST_W-1:0] dest_sum;

   assign dest_sum  = dest + DEST_W'(b_step_offset(mode, idx));
   assign b_addr    = B_BASE | B_W'(dest_sum);
   assign a_addr    = {bank, addr};
   assign addr_next = fixed ? addr : (decr ? addr - 1'b1 : addr + 1'b1);
   assign size_next = size - 1'b1;
   assign last      = (size_next == '0);

endmodule

// File: rtl/gdma_engine.sv
module gdma_engine
   import gdma_pkg::*;
#(
   parameter int              NUM_CH = 8,
   parameter int              SIZE_W = 16,
   parameter int              ADDR_W = 16,
   parameter int              BANK_W = 8,
   parameter int              DEST_W = 8,
   parameter int              B_W    = 16,
   parameter logic [B_W-1:0]  B_BASE = 'h2100,
   localparam int             CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int             A_W    = BANK_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [BANK_W-1:0] cfg_bank,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic [DEST_W-1:0] cfg_dest,
   input  logic [2:0]        cfg_mode,
   input  logic              cfg_b_to_a,
   input  logic              cfg_decr,
   input  logic              cfg_fixed,
   input  logic              arm_we,
   input  logic [NUM_CH-1:0] arm_mask,
   input  logic              kill_we,
   input  logic [NUM_CH-1:0] kill_mask,
   output logic              bus_req,
   output logic [A_W-1:0]    bus_a_addr,
   output logic [B_W-1:0]    bus_b_addr,
   output logic              bus_b_to_a,
   input  logic              bus_ack,
   output logic              busy,
   output logic [NUM_CH-1:0] chan_active
);

   if (NUM_CH < 2 || SIZE_W < 2 || ADDR_W < 2) begin : g_bad_cfg
      $error("gdma_engine: parameter out of range");
   end

   seq_state_t        state_q, state_d;
   logic              any_act, arm_hit, step_en, step_last;
   logic [CH_W-1:0]   sel_ch, cur_q;
   logic [1:0]        idx_q, idx_use;
   logic              live_q;
   logic [BANK_W-1:0] s_bank;
   logic [ADDR_W-1:0] s_addr, addr_nx;
   logic [SIZE_W-1:0] s_size, size_nx;
   logic [DEST_W-1:0] s_dest;
   logic [2:0]        s_mode;
   logic              s_decr, s_fixed;

   gdma_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W), .LOW_FIRST(1'b1)) u_pick (
      .req_mask(chan_active), .any(any_act), .pick(sel_ch)
   );

   gdma_chan_regs #(
      .NUM_CH(NUM_CH), .CH_W(CH_W), .SIZE_W(SIZE_W),
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEST_W(DEST_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_bank(cfg_bank), .cfg_addr(cfg_addr),
      .cfg_size(cfg_size), .cfg_dest(cfg_dest), .cfg_mode(cfg_mode),
      .cfg_b_to_a(cfg_b_to_a), .cfg_decr(cfg_decr), .cfg_fixed(cfg_fixed),
      .arm_we(arm_we), .arm_mask(arm_mask), .kill_we(kill_we), .kill_mask(kill_mask),
      .step_en(step_en), .step_ch(sel_ch), .step_last(step_last),
      .step_addr(addr_nx), .step_size(size_nx), .sel_ch(sel_ch),
      .active(chan_active), .sel_bank(s_bank), .sel_addr(s_addr), .sel_size(s_size),
      .sel_dest(s_dest), .sel_mode(s_mode), .sel_b_to_a(bus_b_to_a),
      .sel_decr(s_decr), .sel_fixed(s_fixed)
   );

   gdma_addr_gen #(
      .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
      .DEST_W(DEST_W), .B_W(B_W), .B_BASE(B_BASE)
   ) u_agen (
      .bank(s_bank), .addr(s_addr), .size(s_size), .dest(s_dest), .mode(s_mode),
      .decr(s_decr), .fixed(s_fixed), .idx(idx_use),
      .a_addr(bus_a_addr), .b_addr(bus_b_addr),
      .addr_next(addr_nx), .size_next(size_nx), .last(step_last)
   );

   // sequencing: one idle cycle between an arm write and the first request
   assign arm_hit = arm_we && |arm_mask;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SEQ_IDLE: if (arm_hit) state_d = SEQ_WAIT;
         SEQ_WAIT: state_d = SEQ_RUN;
         SEQ_RUN:  if (!any_act) state_d = arm_hit ? SEQ_WAIT : SEQ_IDLE;
         default:  state_d = SEQ_IDLE;
      endcase
   end

   assign bus_req = (state_q == SEQ_RUN) && any_act;
   assign step_en = bus_req && bus_ack;
   assign busy    = any_act;
   assign idx_use = (live_q && cur_q == sel_ch) ? idx_q : 2'd0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         cur_q   <= '0;
         live_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (step_en) begin
            cur_q  <= sel_ch;
            idx_q  <= idx_use + 2'd1;
            live_q <= !step_last;
         end
         if (kill_we && kill_mask[cur_q]) live_q <= 1'b0;
      end
   end

   // ---------------- assertions ----------------
   a_r1_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_we && !kill_we && !step_en) |=> ((chan_active & $past(arm_mask)) == $past(arm_mask)));

   a_r1_arm_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_we && !kill_we && !step_en) |=> ((chan_active & $past(chan_active)) == $past(chan_active)));

   a_r2_start_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && arm_we && !kill_we) |=> !bus_req);

   a_r3_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> ((chan_active & ((NUM_CH'(1) << sel_ch) - NUM_CH'(1))) == '0));

   a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_last && !arm_we) |=> !chan_active[$past(sel_ch)]);

   a_r8_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kill_we |=> ((chan_active & $past(kill_mask)) == '0));

   a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !kill_we && !arm_we && !cfg_we) |=>
         (bus_req && $stable(bus_a_addr) && $stable(bus_b_addr) && $stable(bus_b_to_a)));

   a_r10_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

endmodule

// File: tb/sim_gdma_engine.sv
module sim_gdma_engine;

   localparam int NC = 8;
   localparam int SW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_ch = '0;
   logic [7:0] cfg_bank = '0;
   logic [15:0] cfg_addr = '0;
   logic [SW-1:0] cfg_size = '0;
   logic [7:0] cfg_dest = '0;
   logic [2:0] cfg_mode = '0;
   logic cfg_b_to_a = 1'b0, cfg_decr = 1'b0, cfg_fixed = 1'b0;
   logic arm_we = 1'b0;
   logic [NC-1:0] arm_mask = '0;
   logic kill_we = 1'b0;
   logic [NC-1:0] kill_mask = '0;
   logic bus_req, bus_b_to_a, busy;
   logic [23:0] bus_a_addr;
   logic [15:0] bus_b_addr;
   logic bus_ack = 1'b0;
   logic [NC-1:0] chan_active;

   int checks = 0;
   int errors = 0;

   logic [23:0] e_a [0:2047];
   logic [15:0] e_b [0:2047];
   logic        e_d [0:2047];
   int          e_n = 0;

   always #10 clk = ~clk;

   gdma_engine #(.NUM_CH(NC), .SIZE_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_bank(cfg_bank), .cfg_addr(cfg_addr),
      .cfg_size(cfg_size), .cfg_dest(cfg_dest), .cfg_mode(cfg_mode),
      .cfg_b_to_a(cfg_b_to_a), .cfg_decr(cfg_decr), .cfg_fixed(cfg_fixed),
      .arm_we(arm_we), .arm_mask(arm_mask), .kill_we(kill_we), .kill_mask(kill_mask),
      .bus_req(bus_req), .bus_a_addr(bus_a_addr), .bus_b_addr(bus_b_addr),
      .bus_b_to_a(bus_b_to_a), .bus_ack(bus_ack), .busy(busy), .chan_active(chan_active)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int off_of(input int mode, input int j);
      case (mode)
         1:       return (j % 4 == 1) ? 1 : 0;
         3, 7:    return (j / 2) % 2;
         4:       return j % 4;
         5:       return j % 2;
         default: return 0;
      endcase
   endfunction

   // load one channel and append its expected byte stream (first n bytes)
   task automatic load(input int ch, input int bank, input int addr, input int size,
                       input int dest, input int mode, input bit dir, input bit dec,
                       input bit fix, input int n);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_bank = 8'(bank); cfg_addr = 16'(addr);
      cfg_size = SW'(size); cfg_dest = 8'(dest); cfg_mode = 3'(mode);
      cfg_b_to_a = dir; cfg_decr = dec; cfg_fixed = fix;
      @(negedge clk);
      cfg_we = 1'b0;
      for (int j = 0; j < n; j++) begin
         logic [15:0] aa;
         logic [7:0]  bb;
         aa = fix ? 16'(addr) : (dec ? 16'(addr - j) : 16'(addr + j));
         bb = 8'(dest + off_of(mode, j));
         e_a[e_n] = {8'(bank), aa};
         e_b[e_n] = 16'h2100 | {8'h00, bb};
         e_d[e_n] = dir;
         e_n++;
      end
   endtask

   task automatic arm(input logic [NC-1:0] m);
      arm_we = 1'b1; arm_mask = m;
      @(negedge clk);
      arm_we = 1'b0; arm_mask = '0;
   endtask

   // serve requests until idle; compare each request against the expected list
   task automatic drain(input int kill_at, input logic [NC-1:0] kmask, input bit stall,
                        input string req);
      int ptr = 0;
      int cyc = 0;
      bit killed = 0;
      while (busy && cyc < 4000) begin
         bus_ack = 1'b0; kill_we = 1'b0; kill_mask = '0;
         if (!killed && ptr == kill_at) begin
            kill_we = 1'b1; kill_mask = kmask; killed = 1;
         end else if (bus_req) begin
            if (ptr >= e_n) begin
               check(0, req, "extra byte", ptr, e_n);
            end else begin
               check(bus_a_addr == e_a[ptr], req, "A addr", bus_a_addr, e_a[ptr]);
               check(bus_b_addr == e_b[ptr], "R5", "B addr", bus_b_addr, e_b[ptr]);
               check(bus_b_to_a == e_d[ptr], "R6", "direction", bus_b_to_a, e_d[ptr]);
            end
            if (!(stall && cyc % 3 == 1)) begin
               bus_ack = 1'b1;
               ptr++;
            end
         end
         @(negedge clk);
         cyc++;
      end
      bus_ack = 1'b0; kill_we = 1'b0; kill_mask = '0;
      check(ptr == e_n, req, "byte count", ptr, e_n);
      check(!bus_req && !busy && chan_active == '0, "R10", "idle after run",
            {bus_req, busy, chan_active}, 0);
      e_n = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !bus_req && chan_active == '0, "R10", "reset state",
            {bus_req, busy, chan_active}, 0);

      // R2: start delay, then R4/R5/R6 sweep over mode x step x direction
      for (int mode = 0; mode < 8; mode++)
         for (int st = 0; st < 3; st++)
            for (int dir = 0; dir < 2; dir++) begin
               load(mode, 8'h40 + mode, 16'hFFFD, 6, 8'hFD, mode, dir[0],
                    st == 1, st == 2, 6);
               arm(NC'(1) << mode);
               check(!bus_req && busy, "R2", "no request in delay cycle",
                     bus_req, 0);
               drain(-1, '0, dir[0], "R4");
            end

      // R1 / R3: arm writes accumulate; service lowest index first
      load(5, 8'h11, 16'h0100, 2, 8'h10, 1, 1'b0, 1'b0, 1'b0, 0);
      load(2, 8'h22, 16'h0200, 3, 8'h20, 4, 1'b1, 1'b0, 1'b0, 0);
      load(7, 8'h33, 16'h0300, 4, 8'h30, 3, 1'b0, 1'b1, 1'b0, 0);
      e_n = 0;
      load(2, 8'h22, 16'h0200, 3, 8'h20, 4, 1'b1, 1'b0, 1'b0, 3);
      load(5, 8'h11, 16'h0100, 2, 8'h10, 1, 1'b0, 1'b0, 1'b0, 2);
      load(7, 8'h33, 16'h0300, 4, 8'h30, 3, 1'b0, 1'b1, 1'b0, 4);
      arm(8'h04);
      check(chan_active == 8'h04, "R1", "first arm", chan_active, 8'h04);
      arm(8'h80);
      check(chan_active == 8'h84, "R1", "second arm keeps bits", chan_active, 8'h84);
      arm(8'h20);
      check(chan_active == 8'hA4, "R1", "third arm keeps bits", chan_active, 8'hA4);
      drain(-1, '0, 1'b0, "R3");

      // R7: size 0 moves 2^SW bytes, decrementing offset across zero
      load(6, 8'h7E, 16'h0001, 0, 8'hFF, 5, 1'b1, 1'b1, 1'b0, 1 << SW);
      arm(8'h40);
      drain(-1, '0, 1'b1, "R7");

      // R8: kill channel 1 after 4 bytes; channel 3 starts at index 0
      load(1, 8'h01, 16'h1000, 10, 8'h40, 4, 1'b0, 1'b0, 1'b0, 0);
      load(3, 8'h03, 16'h3000, 2, 8'h80, 4, 1'b1, 1'b0, 1'b0, 0);
      e_n = 0;
      load(1, 8'h01, 16'h1000, 10, 8'h40, 4, 1'b0, 1'b0, 1'b0, 4);
      load(3, 8'h03, 16'h3000, 2, 8'h80, 4, 1'b1, 1'b0, 1'b0, 2);
      arm(8'h0A);
      drain(4, 8'h02, 1'b0, "R8");

      // R8: kill wins over arm in the same cycle
      arm_we = 1'b1; arm_mask = 8'h10; kill_we = 1'b1; kill_mask = 8'h10;
      @(negedge clk);
      arm_we = 1'b0; arm_mask = '0; kill_we = 1'b0; kill_mask = '0;
      check(chan_active == '0 && !busy, "R8", "kill beats arm", chan_active, 0);
      repeat (3) @(negedge clk);
      check(!bus_req, "R8", "no request after killed arm", bus_req, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule